// File: doc/BRIEF.md
# Multi-View General Register File

This block holds eight 32-bit general registers and lets every access choose how much of a register it touches. Two read ports and one write port each carry a register index and a view code. The view code selects the whole word, the lower half, the bottom byte, or the second byte (bits 15:8). Only registers 0 to 3 have the two byte views. Registers 4 to 7 offer the word and half views only.

A narrow write merges its field into the current register value and leaves the other bits as they were. A narrow read returns its field shifted down to bit 0, with zeros above it. Reads are combinational. The write takes effect at the rising clock edge, so a read of the register being written in the same cycle still sees the old contents. A byte view aimed at registers 4 to 7 raises a per-port illegal flag. For a read it returns zero, and for a write nothing is stored.

The registers are numbered 0 to 7 in this order: accumulator, counter, data, base, stack pointer, frame base, source index, destination index. The block stores values only and gives no register a special function.

Top module: `gpr_view_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to zero at the clock edge where it is sampled high.
- R2: The view codes are: 2'b00 selects bits 31:0, 2'b01 selects bits 15:0, 2'b10 selects bits 7:0 and 2'b11 selects bits 15:8. The index picks one register from 0 to 7.
- R3: A byte view (2'b10 or 2'b11) used with an index of 4 to 7 is illegal. On a read port it sets that port's bad flag and returns zero. On the write port it sets wr_bad and leaves every register unchanged.
- R4: A legal word write (2'b00) replaces all 32 bits of the selected register with wr_data.
- R5: A half write (2'b01) loads wr_data[15:0] into bits 15:0 and keeps bits 31:16.
- R6: A byte write loads wr_data[7:0] into bits 7:0 (2'b10) or into bits 15:8 (2'b11). All other bits of that register are kept.
- R7: A read returns the selected field placed at bit 0, with every bit above the field driven to zero.
- R8: Reads are combinational. A read of the register being written in the same cycle returns the value held before that clock edge.
- R9: A write changes only the register it indexes. When wr_en is low, no register changes.
- R10: The two read ports work independently and may select different registers and views in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_size | input | 2 | View code for the write |
| wr_data | input | 32 | Write data; the field is taken from the low bits |
| wr_bad | output | 1 | Write request uses an illegal view |
| rd0_idx | input | 3 | Register index for read port 0 |
| rd0_size | input | 2 | View code for read port 0 |
| rd0_data | output | 32 | Zero-extended field for read port 0 |
| rd0_bad | output | 1 | Read port 0 uses an illegal view |
| rd1_idx | input | 3 | Register index for read port 1 |
| rd1_size | input | 2 | View code for read port 1 |
| rd1_data | output | 32 | Zero-extended field for read port 1 |
| rd1_bad | output | 1 | Read port 1 uses an illegal view |

## Verification
The assertions assume the index and view inputs are known (not X) whenever wr_en is high or a read result is observed. They also assume reset is held for at least one edge before any write. The bench drives every input from a fixed-seed generator and changes inputs only at falling edges. Random ops draw all four view codes across all eight indices, so illegal byte requests on registers 4 to 7 appear regularly rather than being filtered out.

// File: rtl/gpr_view_pkg.sv
package gpr_view_pkg;
  parameter int XLEN      = 32;
  parameter int NREGS     = 8;
  parameter int BYTE_REGS = 4;
  parameter int HALFW     = 16;
  parameter int BYTEW     = 8;
  localparam int IDXW     = $clog2(NREGS);

  typedef enum logic [1:0] {
    VW_WORD = 2'b00,
    VW_HALF = 2'b01,
    VW_LOB  = 2'b10,
    VW_HIB  = 2'b11
  } view_e;

  function automatic logic [XLEN-1:0] view_mask(view_e v);
    logic [XLEN-1:0] m;
    case (v)
      VW_WORD: m = '1;
      VW_HALF: m = XLEN'({HALFW{1'b1}});
      VW_LOB:  m = XLEN'({BYTEW{1'b1}});
      default: m = XLEN'({BYTEW{1'b1}}) << BYTEW;
    endcase
    return m;
  endfunction

  function automatic int unsigned view_shift(view_e v);
    return (v == VW_HIB) ? BYTEW : 0;
  endfunction

  function automatic logic view_is_byte(view_e v);
    return (v == VW_LOB) || (v == VW_HIB);
  endfunction

  function automatic logic view_legal(logic [IDXW-1:0] idx, view_e v);
    return !view_is_byte(v) || (int'(idx) < BYTE_REGS);
  endfunction
endpackage

// File: rtl/gpr_read_view.sv
module gpr_read_view
  import gpr_view_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_NREGS = NREGS,
  localparam int P_IDXW = $clog2(P_NREGS)
) (
  input  logic [P_NREGS-1:0][P_XLEN-1:0] regs,
  input  logic [P_IDXW-1:0]              idx,
  input  logic [1:0]                     size,
  output logic [P_XLEN-1:0]              data,
  output logic                           bad
);
  view_e               v;
  logic [P_XLEN-1:0]   raw;
  logic [P_XLEN-1:0]   mask;
  logic                legal;

  always_comb begin
    v     = view_e'(size);
    raw   = regs[idx];
    mask  = view_mask(v);
    legal = view_legal(idx, v);
    bad   = !legal;
    data  = legal ? ((raw & mask) >> view_shift(v)) : '0;
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_view_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_NREGS = NREGS,
  localparam int P_IDXW = $clog2(P_NREGS)
) (
  input  logic                 en,
  input  logic [P_IDXW-1:0]    idx,
  input  logic [1:0]           size,
  input  logic [P_XLEN-1:0]    data,
  input  logic [P_XLEN-1:0]    old_val,
  output logic [P_XLEN-1:0]    new_val,
  output logic [P_XLEN-1:0]    mask,
  output logic                 commit,
  output logic                 bad
);
  view_e             v;
  logic [P_XLEN-1:0] placed;

  always_comb begin
    v      = view_e'(size);
    mask   = view_mask(v);
    placed = view_is_byte(v) ? (P_XLEN'(data[BYTEW-1:0]) << view_shift(v)) : data;
    new_val = (old_val & ~mask) | (placed & mask);
    bad    = en && !view_legal(idx, v);
    commit = en && view_legal(idx, v);
  end
endmodule

// File: rtl/gpr_reg_bank.sv
module gpr_reg_bank
  import gpr_view_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_NREGS = NREGS,
  localparam int P_IDXW = $clog2(P_NREGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           load,
  input  logic [P_IDXW-1:0]              idx,
  input  logic [P_XLEN-1:0]              val,
  output logic [P_NREGS-1:0][P_XLEN-1:0] regs
);
  for (genvar g = 0; g < P_NREGS; g++) begin : g_reg
    logic hit;
    assign hit = load && (idx == P_IDXW'(g));
    always_ff @(posedge clk) begin
      if (rst)      regs[g] <= '0;
      else if (hit) regs[g] <= val;
    end
  end
endmodule

// File: rtl/gpr_view_file.sv
module gpr_view_file
  import gpr_view_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_NREGS = NREGS,
  localparam int P_IDXW = $clog2(P_NREGS),
  localparam int NRD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [P_IDXW-1:0] wr_idx,
  input  logic [1:0]        wr_size,
  input  logic [P_XLEN-1:0] wr_data,
  output logic              wr_bad,
  input  logic [P_IDXW-1:0] rd0_idx,
  input  logic [1:0]        rd0_size,
  output logic [P_XLEN-1:0] rd0_data,
  output logic              rd0_bad,
  input  logic [P_IDXW-1:0] rd1_idx,
  input  logic [1:0]        rd1_size,
  output logic [P_XLEN-1:0] rd1_data,
  output logic              rd1_bad
);
  logic [P_NREGS-1:0][P_XLEN-1:0] regs_q;
  logic [P_XLEN-1:0]              wr_old;
  logic [P_XLEN-1:0]              wr_new;
  logic [P_XLEN-1:0]              wr_mask;
  logic                           wr_commit;

  logic [NRD-1:0][P_IDXW-1:0]     rp_idx;
  logic [NRD-1:0][1:0]            rp_size;
  logic [NRD-1:0][P_XLEN-1:0]     rp_data;
  logic [NRD-1:0]                 rp_bad;

  assign wr_old = regs_q[wr_idx];

  gpr_write_merge #(.P_XLEN(P_XLEN), .P_NREGS(P_NREGS)) u_merge (
    .en      (wr_en),
    .idx     (wr_idx),
    .size    (wr_size),
    .data    (wr_data),
    .old_val (wr_old),
    .new_val (wr_new),
    .mask    (wr_mask),
    .commit  (wr_commit),
    .bad     (wr_bad)
  );

  gpr_reg_bank #(.P_XLEN(P_XLEN), .P_NREGS(P_NREGS)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .load (wr_commit),
    .idx  (wr_idx),
    .val  (wr_new),
    .regs (regs_q)
  );

  assign rp_idx[0]  = rd0_idx;
  assign rp_size[0] = rd0_size;
  assign rp_idx[1]  = rd1_idx;
  assign rp_size[1] = rd1_size;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    gpr_read_view #(.P_XLEN(P_XLEN), .P_NREGS(P_NREGS)) u_rd (
      .regs (regs_q),
      .idx  (rp_idx[p]),
      .size (rp_size[p]),
      .data (rp_data[p]),
      .bad  (rp_bad[p])
    );
  end

  assign rd0_data = rp_data[0];
  assign rd0_bad  = rp_bad[0];
  assign rd1_data = rp_data[1];
  assign rd1_bad  = rp_bad[1];
endmodule

// File: rtl/gpr_view_chk.sv
module gpr_view_chk #(
  parameter int P_XLEN  = 32,
  parameter int P_NREGS = 8,
  localparam int P_IDXW = $clog2(P_NREGS)
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic [P_IDXW-1:0]              wr_idx,
  input logic [1:0]                     wr_size,
  input logic [P_XLEN-1:0]              wr_data,
  input logic                           wr_bad,
  input logic [P_XLEN-1:0]              wr_mask,
  input logic [1:0]                     rd0_size,
  input logic [P_XLEN-1:0]              rd0_data,
  input logic                           rd0_bad,
  input logic [1:0]                     rd1_size,
  input logic [P_XLEN-1:0]              rd1_data,
  input logic                           rd1_bad,
  input logic [P_NREGS-1:0][P_XLEN-1:0] regs_q
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (regs_q == '0));

  a_r3_wr_hi_byte_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx[P_IDXW-1] && wr_size[1]) |-> wr_bad);

  a_r3_bad_no_store: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> (regs_q == $past(regs_q)));

  a_r3_rd0_bad_zero: assert property (@(posedge clk) disable iff (rst)
    rd0_bad |-> (rd0_data == '0));

  a_r3_rd1_bad_zero: assert property (@(posedge clk) disable iff (rst)
    rd1_bad |-> (rd1_data == '0));

  a_r5_keep_outside_field: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bad) |=>
      (((regs_q[$past(wr_idx)] ^ $past(regs_q[wr_idx])) & ~$past(wr_mask)) == '0));

  a_r6_hib_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bad && wr_size == 2'b11) |=>
      (regs_q[$past(wr_idx)][15:8] == $past(wr_data[7:0])));

  a_r7_rd0_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd0_size != 2'b00) |-> (rd0_data[P_XLEN-1:16] == '0));

  a_r7_rd1_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd1_size != 2'b00) |-> (rd1_data[P_XLEN-1:16] == '0));

  for (genvar g = 0; g < P_NREGS; g++) begin : g_keep
    a_r9_other_regs_hold: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_idx != P_IDXW'(g)) |=> (regs_q[g] == $past(regs_q[g])));
  end
endmodule

bind gpr_view_file gpr_view_chk #(.P_XLEN(P_XLEN), .P_NREGS(P_NREGS)) u_chk (.*);

// File: tb/gpr_view_file_bench.sv
`timescale 1ns/1ps
module gpr_view_file_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic        wr_bad;
  logic [2:0]  rd0_idx = '0;
  logic [1:0]  rd0_size = '0;
  logic [31:0] rd0_data;
  logic        rd0_bad;
  logic [2:0]  rd1_idx = '0;
  logic [1:0]  rd1_size = '0;
  logic [31:0] rd1_data;
  logic        rd1_bad;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] mdl [8];

  always #2.5 clk = ~clk;

  gpr_view_file u_gpr_view_file (.*);

  function automatic bit b_illegal(logic [2:0] i, logic [1:0] s);
    return (s >= 2'd2) && (i >= 3'd4);
  endfunction

  function automatic logic [31:0] b_read(logic [2:0] i, logic [1:0] s);
    if (b_illegal(i, s)) return 32'h0;
    case (s)
      2'd0:    return mdl[i];
      2'd1:    return {16'h0, mdl[i][15:0]};
      2'd2:    return {24'h0, mdl[i][7:0]};
      default: return {24'h0, mdl[i][15:8]};
    endcase
  endfunction

  task automatic b_write(logic [2:0] i, logic [1:0] s, logic [31:0] d);
    if (b_illegal(i, s)) return;
    case (s)
      2'd0:    mdl[i]        = d;
      2'd1:    mdl[i][15:0]  = d[15:0];
      2'd2:    mdl[i][7:0]   = d[7:0];
      default: mdl[i][15:8]  = d[7:0];
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at falling edge, check reads before the rising edge
  task automatic op(string tag, bit we, logic [2:0] wi, logic [1:0] ws, logic [31:0] wd,
                    logic [2:0] a, logic [1:0] as, logic [2:0] b, logic [1:0] bs);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
    rd0_idx = a; rd0_size = as; rd1_idx = b; rd1_size = bs;
    #1;
    chk({tag, " rd0"}, rd0_data, b_read(a, as));
    chk({tag, " rd1"}, rd1_data, b_read(b, bs));
    chk({tag, " rd0_bad R3"}, {31'h0, rd0_bad}, {31'h0, b_illegal(a, as)});
    chk({tag, " rd1_bad R3"}, {31'h0, rd1_bad}, {31'h0, b_illegal(b, bs)});
    chk({tag, " wr_bad R3"}, {31'h0, wr_bad}, {31'h0, we && b_illegal(wi, ws)});
    @(posedge clk);
    if (we) b_write(wi, ws, wd);
  endtask

  task automatic dump_all(string tag);
    for (int i = 0; i < 8; i += 2)
      op(tag, 0, 3'd0, 2'd0, 32'h0, 3'(i), 2'd0, 3'(i + 1), 2'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    dump_all("R1 after reset");

    op("R4 word write", 1, 3'd2, 2'd0, 32'h1BA5_83D4, 3'd2, 2'd0, 3'd2, 2'd0);
    op("R8 old value seen", 1, 3'd2, 2'd0, 32'hDEAD_BEEF, 3'd2, 2'd0, 3'd2, 2'd1);
    op("R5 half write", 1, 3'd2, 2'd1, 32'h5555_0A0B, 3'd2, 2'd0, 3'd0, 2'd0);
    op("R6 low byte", 1, 3'd3, 2'd0, 32'hAABB_CCDD, 3'd2, 2'd0, 3'd3, 2'd0);
    op("R6 low byte b", 1, 3'd3, 2'd2, 32'hFFFF_FF11, 3'd3, 2'd0, 3'd3, 2'd2);
    op("R6 high byte", 1, 3'd3, 2'd3, 32'h0000_0022, 3'd3, 2'd0, 3'd3, 2'd3);
    op("R7 views", 1, 3'd6, 2'd0, 32'h8765_4321, 3'd3, 2'd1, 3'd3, 2'd3);
    op("R3 illegal write", 1, 3'd6, 2'd3, 32'h0000_00FF, 3'd6, 2'd0, 3'd6, 2'd2);
    op("R3 after illegal", 0, 3'd0, 2'd0, 32'h0, 3'd6, 2'd0, 3'd7, 2'd3);
    op("R9 wr_en low", 0, 3'd6, 2'd0, 32'hFFFF_FFFF, 3'd6, 2'd0, 3'd6, 2'd1);
    op("R10 split ports", 0, 3'd0, 2'd0, 32'h0, 3'd2, 2'd1, 3'd6, 2'd0);
    dump_all("R9 all regs");

    for (int n = 0; n < 600; n++) begin
      op("R2 random", ($urandom % 4) != 0, 3'($urandom), 2'($urandom), $urandom,
         3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom));
    end
    dump_all("R9 after random");

    @(negedge clk) begin rst = 1'b1; wr_en = 1'b0; end
    @(posedge clk);
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    @(negedge clk) rst = 1'b0;
    dump_all("R1 mid-run reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule